// File: doc/BRIEF.md
# Quad SPI Serial Clock Generator

This block derives the serial clock of a quad SPI controller from the functional clock. It also derives a one-cycle sample strobe and a one-cycle shift strobe, both in the functional clock domain. Two register fields control it: a clock enable and a 16-bit divider. A 32-bit device-control word holds one mode byte for each of four chip selects. The select input picks which byte is used. That byte sets the clock idle level, the sampling edge, the chip-select active level and a data-delay value for the shift engine.

The shift engine raises `frame_active` for as long as a frame lasts. It uses `sample_stb` to capture incoming data and `shift_stb` to launch the next bit. Each strobe is high in the same cycle in which `sclk` shows the edge it belongs to. While the enable is low or no frame is in progress, `sclk` rests at its idle level. Software clears the enable before it loads a new divider and then sets the enable again.

Top module: `qspi_sclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk`, `sample_stb` and `shift_stb` are all 0.
- R2: If `clk_en` or `frame_active` is low at a clock edge, then after that edge `sclk` equals the idle level of the selected chip select and neither strobe is high.
- R3: The clock runs when both `clk_en` and `frame_active` are high. After the first such edge, `sclk` leaves its idle level and one period of P = `clk_div`+1 cycles begins. The non-idle level lasts floor(P/2) cycles and the idle level lasts the rest of the period. Periods repeat back to back.
- R4: A `clk_div` of 0 is treated as 1, so P = 2 and each level lasts one cycle.
- R5: Let the leading edge be the move away from idle and the trailing edge the move back to idle. Phase is bit 8n+2 of `dev_ctrl`. With phase 0, `sample_stb` pulses with each leading edge and `shift_stb` with each trailing edge. With phase 1, the two strobes swap. A strobe is high only in the cycle in which `sclk` shows its edge, and the two strobes are never high together.
- R6: Polarity is bit 8n of `dev_ctrl`. The idle level of `sclk` equals this bit: 0 idles low and 1 idles high.
- R7: If `clk_div` at an edge differs from its value at the previous edge, the period counter restarts. `sclk` goes to idle after that edge and no strobe is produced, even when an edge was due in that cycle. The next cycle starts a full period at the new divider.
- R8: For `cs_sel` = n, `cs_act_high` equals bit 8n+1 of `dev_ctrl` and `data_dly` equals bits 8n+7..8n+3. Only the byte of the selected chip select has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Serial clock enable field |
| clk_div | input | 16 | Divider field; the period is clk_div+1 cycles |
| dev_ctrl | input | 32 | One mode byte per chip select: bit 0 polarity, bit 1 select active high, bit 2 phase, bits 7:3 delay |
| cs_sel | input | 2 | Active chip select |
| frame_active | input | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | One-cycle strobe: sample input data |
| shift_stb | output | 1 | One-cycle strobe: launch the next output bit |
| cs_act_high | output | 1 | Active level of the selected chip select |
| data_dly | output | 5 | Data-delay field of the selected chip select |

## Verification
A change of divider can land in the same cycle as a due clock edge. In that cycle the restart rule and the edge rule both want to act. The bench runs divider 3 (P=4). It changes the divider to 5 at the point where the next edge would return the clock to idle. It then checks that the cycle after that edge has no strobe and an idle clock, and that a clean period of six cycles follows. A second test drops the enable in the middle of a period and expects an immediate, quiet return to idle. After the enable is set again, the first cycle must bring a leading edge.

// File: rtl/qspi_sclk_gen.sv
module qspi_sclk_gen #(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 5,
  localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int MODE_W = 3 + DLY_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic [DIV_W-1:0]         clk_div,
  input  logic [NUM_CS*MODE_W-1:0] dev_ctrl,
  input  logic [SEL_W-1:0]         cs_sel,
  input  logic                     frame_active,
  output logic                     sclk,
  output logic                     sample_stb,
  output logic                     shift_stb,
  output logic                     cs_act_high,
  output logic [DLY_W-1:0]         data_dly
);

  logic [MODE_W-1:0] mode_byte;
  logic              cpol, cpha;
  logic [DIV_W-1:0]  eff_div, half, cnt, div_q;
  logic              run, reload;
  logic              sclk_q, smp_q, shf_q;

  assign mode_byte   = dev_ctrl[cs_sel*MODE_W +: MODE_W];
  assign cpol        = mode_byte[0];
  assign cs_act_high = mode_byte[1];
  assign cpha        = mode_byte[2];
  assign data_dly    = mode_byte[3 +: DLY_W];

  assign eff_div = (clk_div == '0) ? DIV_W'(1) : clk_div;
  assign half    = (eff_div >> 1) + DIV_W'(eff_div[0]);
  assign run     = clk_en & frame_active;
  assign reload  = (clk_div != div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      smp_q  <= 1'b0;
      shf_q  <= 1'b0;
    end else begin
      div_q <= clk_div;
      smp_q <= 1'b0;
      shf_q <= 1'b0;
      if (!run || reload) begin
        cnt    <= '0;
        sclk_q <= cpol;
      end else begin
        cnt <= (cnt == eff_div) ? '0 : cnt + DIV_W'(1);
        if (cnt == '0) begin
          sclk_q <= ~cpol;
          smp_q  <= ~cpha;
          shf_q  <= cpha;
        end else if (cnt == half) begin
          sclk_q <= cpol;
          smp_q  <= cpha;
          shf_q  <= ~cpha;
        end
      end
    end
  end

  assign sclk       = sclk_q;
  assign sample_stb = smp_q;
  assign shift_stb  = shf_q;

endmodule

// File: rtl/qspi_sclk_gen_chk.sv
module qspi_sclk_gen_chk #(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 4,
  parameter int MODE_W = 8,
  parameter int SEL_W  = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clk_en,
  input logic [DIV_W-1:0]         clk_div,
  input logic [NUM_CS*MODE_W-1:0] dev_ctrl,
  input logic [SEL_W-1:0]         cs_sel,
  input logic                     frame_active,
  input logic                     sclk,
  input logic                     sample_stb,
  input logic                     shift_stb
);

  logic sel_pol;
  assign sel_pol = dev_ctrl[cs_sel*MODE_W];

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  a_r5_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> (sclk != $past(sclk)));

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && frame_active) |=> (!sample_stb && !shift_stb));

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && frame_active) |=> (sclk == $past(sel_pol)));

  a_r7_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_div != $past(clk_div)) |=> (!sample_stb && !shift_stb && sclk == $past(sel_pol)));

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!sample_stb && !shift_stb);
    end
  end

endmodule

bind qspi_sclk_gen qspi_sclk_gen_chk #(
  .DIV_W(DIV_W), .NUM_CS(NUM_CS), .MODE_W(MODE_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clk_div(clk_div),
  .dev_ctrl(dev_ctrl), .cs_sel(cs_sel), .frame_active(frame_active),
  .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
);

// File: tb/qspi_sclk_gen_bench.sv
module qspi_sclk_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic [15:0] clk_div = '0;
  logic [31:0] dev_ctrl = '0;
  logic [1:0]  cs_sel = '0;
  logic        frame_active = 1'b0;
  logic        sclk, sample_stb, shift_stb, cs_act_high;
  logic [4:0]  data_dly;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qspi_sclk_gen u_qspi_sclk_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clk_div(clk_div),
    .dev_ctrl(dev_ctrl), .cs_sel(cs_sel), .frame_active(frame_active),
    .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb),
    .cs_act_high(cs_act_high), .data_dly(data_dly)
  );

  typedef struct packed {
    logic [1:0]  cs;
    logic        pol;
    logic        pha;
    logic        hi;
    logic [4:0]  dly;
    logic [15:0] div;
    logic [7:0]  per;
    logic [7:0]  act;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{cs: 2'd0, pol: 1'b0, pha: 1'b0, hi: 1'b1, dly: 5'd2,  div: 16'd3, per: 8'd4, act: 8'd2},
    '{cs: 2'd1, pol: 1'b1, pha: 1'b0, hi: 1'b0, dly: 5'd5,  div: 16'd4, per: 8'd5, act: 8'd2},
    '{cs: 2'd2, pol: 1'b0, pha: 1'b1, hi: 1'b1, dly: 5'd17, div: 16'd1, per: 8'd2, act: 8'd1},
    '{cs: 2'd3, pol: 1'b1, pha: 1'b1, hi: 1'b0, dly: 5'd9,  div: 16'd6, per: 8'd7, act: 8'd3},
    '{cs: 2'd0, pol: 1'b0, pha: 1'b0, hi: 1'b0, dly: 5'd0,  div: 16'd0, per: 8'd2, act: 8'd1},
    '{cs: 2'd2, pol: 1'b1, pha: 1'b0, hi: 1'b1, dly: 5'd30, div: 16'd9, per: 8'd10, act: 8'd5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] make_dc(input vec_t v);
    logic [31:0] dc;
    for (int k = 0; k < 4; k++) begin
      if (k == int'(v.cs)) dc[k*8 +: 8] = {v.dly, v.pha, v.hi, v.pol};
      else                 dc[k*8 +: 8] = {~v.dly, ~v.pha, ~v.hi, ~v.pol};
    end
    return dc;
  endfunction

  // Observe n negedges of a running clock and compare against the period model.
  task automatic observe(input logic pol, input logic pha, input int per, input int act,
                         input int n, input string req);
    int bad = 0;
    int got = 0;
    int want = 0;
    for (int i = 0; i < n; i++) begin
      int m;
      logic es, lead, trail, esmp, eshf;
      @(negedge clk);
      m = i % per;
      es = pol ^ (m < act);
      lead = (m == 0);
      trail = (m == act);
      esmp = pha ? trail : lead;
      eshf = pha ? lead : trail;
      if ({sclk, sample_stb, shift_stb} !== {es, esmp, eshf}) begin
        if (bad == 0) begin
          got = {29'd0, sclk, sample_stb, shift_stb};
          want = {29'd0, es, esmp, eshf};
        end
        bad++;
      end
    end
    check(bad == 0, req, got, want);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check({sclk, sample_stb, shift_stb} === 3'b000, "R1 reset", sclk, 0);
    rst_n = 1'b1;
    clk_en = 1'b1;

    // Table of patterns: R3 R4 R5 R6 R8
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      frame_active = 1'b0;
      dev_ctrl = make_dc(VEC[v]);
      cs_sel = VEC[v].cs;
      clk_div = VEC[v].div;
      repeat (3) @(negedge clk);
      check(sclk === VEC[v].pol && !sample_stb && !shift_stb, "R6 idle level", sclk, VEC[v].pol);
      check(cs_act_high === VEC[v].hi, "R8 select level", cs_act_high, VEC[v].hi);
      check(data_dly === VEC[v].dly, "R8 delay field", data_dly, VEC[v].dly);
      frame_active = 1'b1;
      observe(VEC[v].pol, VEC[v].pha, VEC[v].per, VEC[v].act, 3 * VEC[v].per,
              (VEC[v].div == 0) ? "R4 zero divider" : "R3 R5 waveform");
      frame_active = 1'b0;
      @(negedge clk);
      check(sclk === VEC[v].pol && !sample_stb && !shift_stb, "R2 frame end idle", sclk, VEC[v].pol);
    end

    // R2: enable dropped mid-period, then restored
    dev_ctrl = make_dc(VEC[0]);
    cs_sel = 2'd0;
    clk_div = 16'd3;
    repeat (2) @(negedge clk);
    frame_active = 1'b1;
    @(negedge clk);
    check(sclk === 1'b1 && sample_stb === 1'b1, "R3 first edge", sclk, 1);
    clk_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sclk === 1'b0 && !sample_stb && !shift_stb, "R2 enable low idle", sclk, 0);
    end
    clk_en = 1'b1;
    observe(1'b0, 1'b0, 4, 2, 8, "R2 restart after enable");

    // R7: divider change coinciding with a due trailing edge
    frame_active = 1'b0;
    @(negedge clk);
    frame_active = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clk_div = 16'd5;
    @(negedge clk);
    check(sclk === 1'b0 && !sample_stb && !shift_stb, "R7 reload quiet", {sclk, sample_stb, shift_stb}, 0);
    observe(1'b0, 1'b0, 6, 3, 12, "R7 new period");
    frame_active = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule